// File: doc/BRIEF.md
# Interleaved Dual-Lane Adder/Subtractor

This block adds or subtracts two unsigned operands at one result per clock while giving each arithmetic evaluation two full clock periods to settle. It holds two identical lanes. Each lane owns its operand registers, a single carry-chain adder and a result register. A one-bit phase machine alternates between two states. In PH_EVEN, lane A captures the incoming operands and lane B retires its result. In PH_ODD, lane B captures and lane A retires. The transitions are PH_EVEN to PH_ODD and PH_ODD to PH_EVEN on every clock, and reset forces PH_EVEN. A final register takes the lane that has just retired, so one stream of results leaves the block.

Subtraction uses the same adder as addition. When the mode bit is set, the lane feeds the bitwise complement of the second operand and a carry-in of one. The mode bit and the valid strobe travel with the operands, so each result keeps the mode it was launched with.

Top module: `ilv_addsub`

## Requirements
- R1: With the subtract input low, the result equals a + b as a WIDTH+1 bit value, and the top bit is the carry-out (WIDTH=8: 255+255 gives 510).
- R2: With the subtract input high, result bits WIDTH-1..0 hold (a - b) modulo 2^WIDTH. Result bit WIDTH is 1 when a >= b and 0 when a < b (5-10 gives 0x0FB, 77-77 gives 0x100).
- R3: A pair sampled at a clock edge appears on the outputs right after the third following edge. Pairs presented on consecutive edges each produce a result on consecutive edges, so the block returns one result per clock.
- R4: The subtract input is sampled together with the operands. Changing it on a later edge does not alter the result of a pair already captured.
- R5: The output valid flag repeats the input valid strobe with the same three-edge latency. A cycle with the strobe low gives a cycle with the output valid low.
- R6: A synchronous active-high reset clears the output valid flag and the result to zero and empties both lanes. After reset the output valid flag stays low until the first pair launched after reset has completed its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| do_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| in_valid | input | 1 | Operand pair is valid |
| result | output | WIDTH+1 | Sum or difference; top bit is carry-out |
| out_valid | output | 1 | Result is valid |

## Verification
The bench builds the block at its default WIDTH of 8. At that width the full-scale carry (255+255), the full-range borrow (0-255) and the equality case of subtraction are concrete vectors. A stream of pairs on consecutive clocks runs through both lanes with modes that alternate between them. Directed tests follow: first-result latency after reset, a mode change made right after capture, and a reset applied while the pipeline is full.

// File: rtl/ilv_addsub_pkg.sv
package ilv_addsub_pkg;
    // Which lane captures operands in the current cycle.
    typedef enum logic {
        PH_EVEN = 1'b0,   // lane A captures, lane B retires
        PH_ODD  = 1'b1    // lane B captures, lane A retires
    } phase_t;

    localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/ilv_phase_fsm.sv
module ilv_phase_fsm
    import ilv_addsub_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase
);
    phase_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EVEN: state_d = PH_ODD;
            PH_ODD:  state_d = PH_EVEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_EVEN;
        else     state_q <= state_d;
    end

    assign phase = state_q;
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             turn,      // this lane's phase
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             do_sub,
    input  logic             in_valid,
    output logic [WIDTH:0]   lane_res,
    output logic             lane_vld
);
    localparam int unsigned RW = WIDTH + 1;

    logic [WIDTH-1:0] a_q, b_q;
    logic             sub_q, vld_q;
    logic [WIDTH-1:0] b_eff;
    logic [RW-1:0]    sum;

    // Operand stage: loads on this lane's phase, then holds for two cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            sub_q <= 1'b0;
            vld_q <= 1'b0;
        end else if (turn) begin
            a_q   <= op_a;
            b_q   <= op_b;
            sub_q <= do_sub;
            vld_q <= in_valid;
        end
    end

    // One carry chain: complement b and force carry-in for subtraction.
    always_comb begin
        b_eff = sub_q ? ~b_q : b_q;
        sum   = {1'b0, a_q} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_q};
    end

    // Result stage: same phase, so the chain has two clock periods.
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_res <= '0;
            lane_vld <= 1'b0;
        end else if (turn) begin
            lane_res <= sum;
            lane_vld <= vld_q;
        end
    end
endmodule

// File: rtl/ilv_addsub.sv
module ilv_addsub
    import ilv_addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             do_sub,
    input  logic             in_valid,
    output logic [WIDTH:0]   result,
    output logic             out_valid
);
    localparam int unsigned RW = WIDTH + 1;

    phase_t          phase_q;
    logic [RW-1:0]   lane_res [NUM_LANES];
    logic            lane_vld [NUM_LANES];
    logic            turn     [NUM_LANES];

    ilv_phase_fsm u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase_q)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign turn[i] = (i == 0) ? (phase_q == PH_EVEN) : (phase_q == PH_ODD);

        ilv_lane #(.WIDTH(WIDTH)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .turn     (turn[i]),
            .op_a     (op_a),
            .op_b     (op_b),
            .do_sub   (do_sub),
            .in_valid (in_valid),
            .lane_res (lane_res[i]),
            .lane_vld (lane_vld[i])
        );
    end

    // Merge: take the lane whose result register loaded on the last edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_EVEN: begin
                    result    <= lane_res[1];
                    out_valid <= lane_vld[1];
                end
                PH_ODD: begin
                    result    <= lane_res[0];
                    out_valid <= lane_vld[0];
                end
            endcase
        end
    end
endmodule

// File: rtl/ilv_addsub_chk.sv
module ilv_addsub_chk
    import ilv_addsub_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             do_sub,
    input logic             in_valid,
    input logic [WIDTH:0]   result,
    input logic             out_valid,
    input phase_t           phase
);
    localparam int unsigned RW = WIDTH + 1;

    logic [2:0]       since_rst;
    logic [WIDTH-1:0] nb;

    assign nb = ~op_b;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    // R3
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd0) |-> (phase != $past(phase)));

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R6
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 3'd4) |-> !out_valid);

    // R1
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4 && $past(in_valid, 4) && !$past(do_sub, 4)) |->
        (result == ({1'b0, $past(op_a, 4)} + {1'b0, $past(op_b, 4)})));

    // R2
    sub_result_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4 && $past(in_valid, 4) && $past(do_sub, 4)) |->
        (result == ({1'b0, $past(op_a, 4)} + {1'b0, $past(nb, 4)} + RW'(1))));
endmodule

bind ilv_addsub ilv_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .do_sub    (do_sub),
    .in_valid  (in_valid),
    .result    (result),
    .out_valid (out_valid),
    .phase     (phase_q)
);

// File: tb/ilv_addsub_test.sv
module ilv_addsub_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NV = 12;
    // {a, b, sub, valid}
    localparam logic [2*W+1:0] VEC [NV] = '{
        {8'd200, 8'd100, 1'b0, 1'b1},
        {8'd255, 8'd255, 1'b0, 1'b1},
        {8'd0,   8'd0,   1'b0, 1'b1},
        {8'd10,  8'd5,   1'b1, 1'b1},
        {8'd5,   8'd10,  1'b1, 1'b1},
        {8'd77,  8'd77,  1'b1, 1'b1},
        {8'd0,   8'd255, 1'b1, 1'b1},
        {8'd1,   8'd1,   1'b0, 1'b0},
        {8'd255, 8'd0,   1'b1, 1'b1},
        {8'd1,   8'd255, 1'b0, 1'b1},
        {8'd128, 8'd127, 1'b0, 1'b1},
        {8'd0,   8'd1,   1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         do_sub = 1'b0, in_valid = 1'b0;
    logic [W:0]   result;
    logic         out_valid;
    int           checks = 0;
    int           errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_addsub #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .do_sub(do_sub), .in_valid(in_valid),
        .result(result), .out_valid(out_valid)
    );

    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic s);
        int d;
        if (!s) return (W+1)'(int'(a) + int'(b));
        d = int'(a) - int'(b);
        return {(a >= b), W'(d + 256)};
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s, input logic v);
        op_a = a; op_b = b; do_sub = s; in_valid = v;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive('0, '0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R6: reset state at the ports
        check("R6 reset valid", {{W{1'b0}}, out_valid}, '0);
        check("R6 reset result", result, '0);

        // Table: one pair per clock, results checked four negedges later (R1 R2 R3 R5)
        for (int c = 0; c < NV + 4; c++) begin
            if (c >= 4) begin
                logic [2*W+1:0] v;
                v = VEC[c-4];
                check("R5 valid stream", {{W{1'b0}}, out_valid}, {{W{1'b0}}, v[0]});
                if (v[0])
                    check(v[1] ? "R2 sub stream" : "R1 add stream", result,
                          model(v[2*W+1:W+2], v[W+1:2], v[1]));
            end
            if (c < NV) begin
                logic [2*W+1:0] v;
                v = VEC[c];
                drive(v[2*W+1:W+2], v[W+1:2], v[1], v[0]);
            end else begin
                drive('0, '0, 1'b0, 1'b0);
            end
            @(negedge clk);
        end

        // R6 / R3: first pair after reset; valid low until the latency completes
        do_reset();
        drive(8'd3, 8'd4, 1'b0, 1'b1);
        @(negedge clk);
        drive('0, '0, 1'b0, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            check("R6 valid held low", {{W{1'b0}}, out_valid}, '0);
            @(negedge clk);
        end
        check("R3 first valid", {{W{1'b0}}, out_valid}, 9'd1);
        check("R3 first result", result, 9'd7);

        // R4: mode flipped right after capture must not affect the launched pair
        drive(8'd9, 8'd4, 1'b1, 1'b1);
        @(negedge clk);
        drive(8'd9, 8'd4, 1'b0, 1'b0);
        @(negedge clk);
        drive(8'd9, 8'd4, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R4 mode valid", {{W{1'b0}}, out_valid}, 9'd1);
        check("R4 mode kept", result, 9'h105);
        @(negedge clk);
        check("R5 gap valid low", {{W{1'b0}}, out_valid}, '0);

        // R6: reset while the pipeline is full empties it
        drive(8'd50, 8'd60, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive('0, '0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            check("R6 flushed valid", {{W{1'b0}}, out_valid}, '0);
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule